// File: doc/BRIEF.md
# Single-Wire Bus Slave Protocol Engine

This block is the protocol layer of a slave on a Manchester-coded single-wire bus. A separate bit-timing unit watches the line. It reports to this engine: a long high standby pulse, the falling edge that opens a start header, the end of each bit slot together with the direction of its middle edge, a slot with no middle edge, and a line held low through a master-acknowledge slot. The engine works out what each slot means. It tracks whether the slave is idle, in standby, in an active command, or paused in hold. It checks the header byte and matches the slave's address in either the short 8-bit or the long 12-bit form. It tells the timing unit when to drive a slave acknowledge and when to drive data bits of its own.

On the application side, each received command or data byte comes out with a one-cycle strobe. A command-valid input decides whether the command byte is accepted. When the master asks for more data and the application marks the next byte as slave-sent, the engine takes a transmit byte at that acknowledge and shifts it out MSB first. The set of commands and what they mean are left to the application.

The family code and the choice of 8-bit or 12-bit addressing are parameters. The device code comes from input pins.

Top module: `usl_slave`

## Requirements
- R1: After reset the engine is Idle (mode_o = 0, where 0 is Idle, 1 is Standby, 2 is Active and 3 is Hold). In Idle, header starts and slot events are ignored: mode stays 0, and no acknowledge, data drive or strobe appears.
- R2: A standby pulse moves the engine to Standby (mode 1) on the next cycle from any mode. It takes precedence over any slot event in the same cycle.
- R3: In Standby a header start makes the engine Active. The next byte must be 0x55 and must be followed by a MAK (a slot whose edge carries value 1); otherwise the engine goes to Idle. No acknowledge is driven in the slot after the header.
- R4: With 8-bit addressing the address byte must equal {FAMILY, dev_code_i[3:0]}, with the family in the upper nibble. A match is acknowledged after the next MAK or NoMAK. A mismatch sends the engine to Idle with no acknowledge.
- R5: With 12-bit addressing the first address byte must be {4'b1111, FAMILY} and gets no acknowledge. The second byte must equal dev_code_i[7:0] and is acknowledged. Any mismatch sends the engine to Idle. An 8-bit engine that sees 1111 in the family position goes to Idle.
- R6: The command byte, the first byte after the address, is strobed on rx_stb_o with rx_cmd_o = 1 and the byte on rx_byte_o. If cmd_ok_i is low at the following acknowledge bit, the engine goes to Idle with no acknowledge.
- R7: A NoMAK (value 0) right after the complete address is still acknowledged, and the engine then returns to Standby. A NoMAK after the header, or after the 12-bit high address byte, sends it to Idle.
- R8: A NoMAK after the command or a data byte is acknowledged, and the engine then returns to Standby. sak_drive_o stays high for the whole slave-acknowledge slot and falls when that slot ends.
- R9: A slot with no middle edge while a byte is being received, or in a MAK slot without hold, sends the engine to Idle.
- R10: hold_i in a MAK slot puts the engine in Hold (mode 3), even if a missing-edge report comes in the same cycle. Missing-edge slots are ignored in Hold. The next edge slot acts as the acknowledge bit, MAK or NoMAK.
- R11: A MAK after the command or a data byte, with tx_dir_i high, raises tx_take_o in that cycle and captures tx_byte_i. In the next byte's eight slots tx_drive_o is high and tx_bit_o gives the byte MSB first. tx_drive_o and sak_drive_o are never high together.
- R12: Data bytes the master sends after the command are strobed with rx_cmd_o = 0, assembled MSB first.
- R13: After a clean end (in Standby), a header start with no standby pulse begins a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_i | input | 1 | Standby pulse seen (one cycle) |
| hdr_start_i | input | 1 | High-to-low edge after the setup time: header begins |
| slot_edge_i | input | 1 | Bit slot ended with a middle edge |
| slot_bit_i | input | 1 | Value of that edge: 1 rising, 0 falling |
| slot_miss_i | input | 1 | Bit slot ended without a middle edge |
| hold_i | input | 1 | Line held low through a MAK slot |
| dev_code_i | input | 8 | Device code pins (low nibble used in 8-bit mode) |
| cmd_ok_i | input | 1 | Application accepts the strobed command byte |
| tx_dir_i | input | 1 | Next data byte is sent by this slave |
| tx_byte_i | input | 8 | Byte to transmit, taken on tx_take_o |
| sak_drive_o | output | 1 | Drive a rising middle edge in the current slot |
| tx_drive_o | output | 1 | Drive the current data bit |
| tx_bit_o | output | 1 | Data bit to drive |
| tx_take_o | output | 1 | tx_byte_i captured this cycle |
| rx_byte_o | output | 8 | Received byte |
| rx_stb_o | output | 1 | rx_byte_o valid (one cycle) |
| rx_cmd_o | output | 1 | The strobed byte is the command byte |
| mode_o | output | 2 | 0 Idle, 1 Standby, 2 Active, 3 Hold |

## Verification
Two pairs of events can fall in the same cycle. A standby pulse can arrive together with a slot edge in the middle of a byte, and the master can hold the line low in a MAK slot while the timing unit also reports that slot as missing its edge. The bench provokes the first in a directed case and the second every time it exercises hold. It judges the outcome through mode_o on the next cycle: Standby wins in the first case and Hold wins in the second. It then checks that the command continues normally after hold ends.

// File: rtl/usl_pkg.sv
package usl_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam logic [BYTE_W-1:0] HDR_CODE = 8'h55;
  localparam logic [NIB_W-1:0]  LONG_TAG = 4'hF;

  localparam logic [1:0] MODE_IDLE = 2'd0;
  localparam logic [1:0] MODE_STBY = 2'd1;
  localparam logic [1:0] MODE_ACT  = 2'd2;
  localparam logic [1:0] MODE_HOLD = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STBY, ST_RX, ST_TX, ST_MAK, ST_SAK, ST_HOLD
  } usl_state_e;

  typedef enum logic [2:0] {
    K_HDR, K_AHI, K_ADR, K_CMD, K_DAT
  } usl_kind_e;

endpackage

// File: rtl/usl_shift.sv
module usl_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] full_o,
  output logic         last_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  data_q, data_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          data_en, cnt_en;

  always_comb begin
    data_d  = data_q;
    cnt_d   = cnt_q;
    data_en = 1'b0;
    cnt_en  = 1'b0;
    if (load_i) begin
      data_d  = load_val_i;
      cnt_d   = '0;
      data_en = 1'b1;
      cnt_en  = 1'b1;
    end else if (shift_i) begin
      data_d  = {data_q[W-2:0], bit_i};
      cnt_d   = cnt_q + 1'b1;
      data_en = 1'b1;
      cnt_en  = 1'b1;
    end else if (clr_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (data_en) data_q <= data_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  assign data_o = data_q;
  assign full_o = {data_q[W-2:0], bit_i};
  assign last_o = (cnt_q == CW'(W - 1));

endmodule

// File: rtl/usl_addr_match.sv
module usl_addr_match
  import usl_pkg::*;
#(
  parameter bit              ADDR12 = 1'b0,
  parameter logic [NIB_W-1:0] FAMILY = 4'hA
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] dev_code_i,
  output logic              hi_ok_o,
  output logic              lo_ok_o
);
  generate
    if (ADDR12) begin : g_long
      assign hi_ok_o = (byte_i == {LONG_TAG, FAMILY});
      assign lo_ok_o = (byte_i == dev_code_i);
    end else begin : g_short
      logic unused_hi;
      assign unused_hi = ^dev_code_i[BYTE_W-1:NIB_W];
      assign hi_ok_o   = 1'b0;
      assign lo_ok_o   = (byte_i == {FAMILY, dev_code_i[NIB_W-1:0]});
    end
  endgenerate

endmodule

// File: rtl/usl_ctrl.sv
module usl_ctrl
  import usl_pkg::*;
#(
  parameter bit ADDR12 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_i,
  input  logic              hdr_start_i,
  input  logic              slot_edge_i,
  input  logic              slot_bit_i,
  input  logic              slot_miss_i,
  input  logic              hold_i,
  input  logic              cmd_ok_i,
  input  logic              tx_dir_i,
  input  logic              sh_last_i,
  input  logic [BYTE_W-1:0] sh_full_i,
  input  logic              hi_ok_i,
  input  logic              lo_ok_i,
  output logic              sh_clr_o,
  output logic              sh_shift_o,
  output logic              sh_load_o,
  output logic              sak_drive_o,
  output logic              tx_drive_o,
  output logic              tx_take_o,
  output logic              rx_stb_o,
  output logic              rx_cmd_o,
  output logic [1:0]        mode_o
);
  localparam usl_kind_e FIRST_ADDR = ADDR12 ? K_AHI : K_ADR;

  usl_state_e st_q, st_d;
  usl_kind_e  kind_q, kind_d;
  logic       end_q, end_d;
  logic       drv_q, drv_d;
  logic       txm_q, txm_d;
  logic       stb_q, stb_d;
  logic       cmd_q, cmd_d;
  logic       ack_ev;
  logic       slot_ev;

  assign slot_ev = slot_edge_i | slot_miss_i;
  assign ack_ev  = !stby_i && slot_edge_i &&
                   ((st_q == ST_MAK && !hold_i) || st_q == ST_HOLD);

  always_comb begin
    st_d       = st_q;
    kind_d     = kind_q;
    end_d      = end_q;
    drv_d      = drv_q;
    txm_d      = txm_q;
    stb_d      = 1'b0;
    cmd_d      = cmd_q;
    sh_clr_o   = 1'b0;
    sh_shift_o = 1'b0;
    sh_load_o  = 1'b0;
    tx_take_o  = 1'b0;
    if (stby_i) begin
      st_d = ST_STBY;
    end else begin
      unique case (st_q)
        ST_STBY: begin
          if (hdr_start_i) begin
            st_d     = ST_RX;
            kind_d   = K_HDR;
            sh_clr_o = 1'b1;
          end
        end
        ST_RX: begin
          if (slot_miss_i) begin
            st_d = ST_IDLE;
          end else if (slot_edge_i) begin
            sh_shift_o = 1'b1;
            if (sh_last_i) begin
              st_d = ST_MAK;
              unique case (kind_q)
                K_HDR:   if (sh_full_i != HDR_CODE) st_d = ST_IDLE;
                K_AHI:   if (!hi_ok_i) st_d = ST_IDLE;
                K_ADR:   if (!lo_ok_i) st_d = ST_IDLE;
                default: begin
                  stb_d = 1'b1;
                  cmd_d = (kind_q == K_CMD);
                end
              endcase
            end
          end
        end
        ST_TX: begin
          if (slot_ev) begin
            sh_shift_o = 1'b1;
            if (sh_last_i) st_d = ST_MAK;
          end
        end
        ST_MAK: begin
          if (hold_i)           st_d = ST_HOLD;
          else if (slot_miss_i) st_d = ST_IDLE;
        end
        ST_SAK: begin
          if (slot_ev) begin
            if (end_q) begin
              st_d = ST_STBY;
            end else if (txm_q) begin
              st_d = ST_TX;
            end else begin
              st_d     = ST_RX;
              sh_clr_o = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end

    if (ack_ev) begin
      st_d  = ST_SAK;
      end_d = !slot_bit_i;
      drv_d = 1'b1;
      txm_d = 1'b0;
      unique case (kind_q)
        K_HDR: begin
          drv_d  = 1'b0;
          kind_d = FIRST_ADDR;
          if (!slot_bit_i) st_d = ST_IDLE;
        end
        K_AHI: begin
          drv_d  = 1'b0;
          kind_d = K_ADR;
          if (!slot_bit_i) st_d = ST_IDLE;
        end
        K_ADR: kind_d = K_CMD;
        default: begin
          kind_d = K_DAT;
          if (kind_q == K_CMD && !cmd_ok_i) begin
            st_d = ST_IDLE;
          end else if (slot_bit_i && tx_dir_i) begin
            txm_d     = 1'b1;
            sh_load_o = 1'b1;
            tx_take_o = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_HDR;
      end_q  <= 1'b0;
      drv_q  <= 1'b0;
      txm_q  <= 1'b0;
      stb_q  <= 1'b0;
      cmd_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      end_q  <= end_d;
      drv_q  <= drv_d;
      txm_q  <= txm_d;
      stb_q  <= stb_d;
      cmd_q  <= cmd_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_IDLE: mode_o = MODE_IDLE;
      ST_STBY: mode_o = MODE_STBY;
      ST_HOLD: mode_o = MODE_HOLD;
      default: mode_o = MODE_ACT;
    endcase
  end

  assign sak_drive_o = (st_q == ST_SAK) && drv_q;
  assign tx_drive_o  = (st_q == ST_TX);
  assign rx_stb_o    = stb_q;
  assign rx_cmd_o    = cmd_q;

endmodule

// File: rtl/usl_slave.sv
module usl_slave
  import usl_pkg::*;
#(
  parameter bit               ADDR12 = 1'b0,
  parameter logic [NIB_W-1:0] FAMILY = 4'hA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stby_i,
  input  logic        hdr_start_i,
  input  logic        slot_edge_i,
  input  logic        slot_bit_i,
  input  logic        slot_miss_i,
  input  logic        hold_i,
  input  logic [7:0]  dev_code_i,
  input  logic        cmd_ok_i,
  input  logic        tx_dir_i,
  input  logic [7:0]  tx_byte_i,
  output logic        sak_drive_o,
  output logic        tx_drive_o,
  output logic        tx_bit_o,
  output logic        tx_take_o,
  output logic [7:0]  rx_byte_o,
  output logic        rx_stb_o,
  output logic        rx_cmd_o,
  output logic [1:0]  mode_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              sh_clr, sh_shift, sh_load, sh_last;
  logic [BYTE_W-1:0] sh_data, sh_full;
  logic              hi_ok, lo_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  usl_shift #(.W(BYTE_W)) i_shift (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clr_i      (sh_clr),
    .load_i     (sh_load),
    .load_val_i (tx_byte_i),
    .shift_i    (sh_shift),
    .bit_i      (slot_bit_i),
    .data_o     (sh_data),
    .full_o     (sh_full),
    .last_o     (sh_last)
  );

  usl_addr_match #(.ADDR12(ADDR12), .FAMILY(FAMILY)) i_match (
    .byte_i     (sh_full),
    .dev_code_i (dev_code_i),
    .hi_ok_o    (hi_ok),
    .lo_ok_o    (lo_ok)
  );

  usl_ctrl #(.ADDR12(ADDR12)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .stby_i      (stby_i),
    .hdr_start_i (hdr_start_i),
    .slot_edge_i (slot_edge_i),
    .slot_bit_i  (slot_bit_i),
    .slot_miss_i (slot_miss_i),
    .hold_i      (hold_i),
    .cmd_ok_i    (cmd_ok_i),
    .tx_dir_i    (tx_dir_i),
    .sh_last_i   (sh_last),
    .sh_full_i   (sh_full),
    .hi_ok_i     (hi_ok),
    .lo_ok_i     (lo_ok),
    .sh_clr_o    (sh_clr),
    .sh_shift_o  (sh_shift),
    .sh_load_o   (sh_load),
    .sak_drive_o (sak_drive_o),
    .tx_drive_o  (tx_drive_o),
    .tx_take_o   (tx_take_o),
    .rx_stb_o    (rx_stb_o),
    .rx_cmd_o    (rx_cmd_o),
    .mode_o      (mode_o)
  );

  assign tx_bit_o  = sh_data[BYTE_W-1];
  assign rx_byte_o = sh_data;

endmodule

// File: rtl/usl_slave_chk.sv
module usl_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stby_i,
  input logic       slot_edge_i,
  input logic       slot_bit_i,
  input logic [1:0] mode_o,
  input logic       sak_drive_o,
  input logic       tx_drive_o,
  input logic       tx_take_o,
  input logic       rx_stb_o
);
  AST_IDLE_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !stby_i) |=> (mode_o == 2'd0)); // R1

  AST_STBY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stby_i |=> (mode_o == 2'd1)); // R2

  AST_SAK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sak_drive_o |-> (mode_o == 2'd2)); // R8

  AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sak_drive_o && tx_drive_o)); // R11

  AST_TAKE_ON_MAK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |-> (slot_edge_i && slot_bit_i && !stby_i)); // R11

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb_o |=> !rx_stb_o); // R6

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3 && !stby_i && !slot_edge_i) |=> (mode_o == 2'd3)); // R10

endmodule

bind usl_slave usl_slave_chk i_chk (.rst_n(rst_core_n), .*);

// File: tb/test_usl_slave.sv
module test_usl_slave;
  localparam logic [3:0] FAM_A = 4'hA;
  localparam logic [3:0] FAM_B = 4'h3;
  localparam logic [7:0] DEV_A = 8'h05;
  localparam logic [7:0] DEV_B = 8'h6C;
  localparam logic [7:0] ADR_A = {FAM_A, DEV_A[3:0]};
  localparam logic [7:0] HI_B  = {4'hF, FAM_B};

  logic clk, rst_n;
  logic stby_i, hdr_start_i, slot_edge_i, slot_bit_i, slot_miss_i, hold_i;
  logic cmd_ok_i, tx_dir_i;
  logic [7:0] tx_byte_i;
  logic a_sak, a_txd, a_txb, a_take, a_stb, a_cmd;
  logic b_sak, b_txd, b_txb, b_take, b_stb, b_cmd;
  logic [7:0] a_rx, b_rx;
  logic [1:0] a_mode, b_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  usl_slave #(.ADDR12(1'b0), .FAMILY(FAM_A)) i_usl_slave (
    .clk(clk), .rst_n(rst_n), .stby_i(stby_i), .hdr_start_i(hdr_start_i),
    .slot_edge_i(slot_edge_i), .slot_bit_i(slot_bit_i), .slot_miss_i(slot_miss_i),
    .hold_i(hold_i), .dev_code_i(DEV_A), .cmd_ok_i(cmd_ok_i), .tx_dir_i(tx_dir_i),
    .tx_byte_i(tx_byte_i), .sak_drive_o(a_sak), .tx_drive_o(a_txd), .tx_bit_o(a_txb),
    .tx_take_o(a_take), .rx_byte_o(a_rx), .rx_stb_o(a_stb), .rx_cmd_o(a_cmd),
    .mode_o(a_mode));

  usl_slave #(.ADDR12(1'b1), .FAMILY(FAM_B)) i_usl_slave_w (
    .clk(clk), .rst_n(rst_n), .stby_i(stby_i), .hdr_start_i(hdr_start_i),
    .slot_edge_i(slot_edge_i), .slot_bit_i(slot_bit_i), .slot_miss_i(slot_miss_i),
    .hold_i(hold_i), .dev_code_i(DEV_B), .cmd_ok_i(cmd_ok_i), .tx_dir_i(tx_dir_i),
    .tx_byte_i(tx_byte_i), .sak_drive_o(b_sak), .tx_drive_o(b_txd), .tx_bit_o(b_txb),
    .tx_take_o(b_take), .rx_byte_o(b_rx), .rx_stb_o(b_stb), .rx_cmd_o(b_cmd),
    .mode_o(b_mode));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    stby_i = 0; hdr_start_i = 0; slot_edge_i = 0; slot_miss_i = 0; hold_i = 0;
  endtask

  task automatic send_bit(input logic b);
    slot_edge_i = 1; slot_bit_i = b; step();
  endtask

  task automatic miss_slot();
    slot_miss_i = 1; step();
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  function automatic bit sel_a(input bit w12, input logic [7:0] adr);
    return !w12 && adr == ADR_A;
  endfunction

  function automatic bit sel_b(input bit w12, input logic [7:0] hi, input logic [7:0] adr);
    return w12 && hi == HI_B && adr == DEV_B;
  endfunction

  task automatic modes(input string tag, input logic [1:0] ea, input logic [1:0] eb);
    chk({tag, " mode A"}, 32'(a_mode), 32'(ea));
    chk({tag, " mode B"}, 32'(b_mode), 32'(eb));
  endtask

  // Acknowledge pair: master bit, then slave slot. Optional hold before the master bit.
  task automatic ack(input string tag, input bit mak, input bit ea, input bit eb,
                     input bit hold, input bit ta, input bit tb);
    if (hold) begin
      hold_i = 1; slot_miss_i = 1; step();
      modes("R10 hold entry", ea ? 2'd3 : 2'd0, eb ? 2'd3 : 2'd0);
      miss_slot(); miss_slot();
      modes("R10 hold keeps", ea ? 2'd3 : 2'd0, eb ? 2'd3 : 2'd0);
    end
    slot_edge_i = 1; slot_bit_i = mak;
    #1;
    chk("R11 take A", 32'(a_take), 32'(ta));
    chk("R11 take B", 32'(b_take), 32'(tb));
    step();
    chk({tag, " sak A"}, 32'(a_sak), 32'(ea));
    chk({tag, " sak B"}, 32'(b_sak), 32'(eb));
    if (ea || eb) send_bit(1'b1);
    else          miss_slot();
    chk("R8 sak released A", 32'(a_sak), 32'd0);
  endtask

  task automatic open_cmd(input bit use_stby);
    if (use_stby) begin
      stby_i = 1; step();
      modes("R2 standby", 2'd1, 2'd1);
    end
    hdr_start_i = 1; step();
    send_byte(8'h55);
    ack("R3 header", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic run_txn(input bit w12, input logic [7:0] hi, input logic [7:0] adr,
                         input bit poll, input bit ok, input int nb, input bit use_hold);
    bit sa, sb, ta, tb;
    logic [7:0] cmd;
    logic [7:0] dat [4];
    bit dir [4];
    sa = sel_a(w12, adr);
    sb = sel_b(w12, hi, adr);
    stby_i = 1; step();
    modes("R2 standby", 2'd1, 2'd1);
    hdr_start_i = 1; step();
    modes("R3 header start", 2'd2, 2'd2);
    send_byte(8'h55);
    ack("R3 header", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    if (w12) begin
      send_byte(hi);
      chk("R5 short device drops on 1111", 32'(a_mode), 32'd0);
      chk("R5 high byte match", 32'(b_mode), (hi == HI_B) ? 32'd2 : 32'd0);
      ack("R5 high byte", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    send_byte(adr);
    if (poll) begin
      ack("R7 poll", 1'b0, sa, sb, 1'b0, 1'b0, 1'b0);
      modes("R7 poll end", sa ? 2'd1 : 2'd0, sb ? 2'd1 : 2'd0);
      return;
    end
    ack("R4 R5 address", 1'b1, sa, sb, use_hold && (sa || sb), 1'b0, 1'b0);
    modes("R4 R5 after address", sa ? 2'd2 : 2'd0, sb ? 2'd2 : 2'd0);
    for (int k = 0; k < 4; k++) begin
      dat[k] = 8'($urandom);
      dir[k] = 1'($urandom);
    end
    cmd = 8'($urandom);
    cmd_ok_i = ok;
    send_byte(cmd);
    chk("R6 cmd strobe A", 32'(a_stb), 32'(sa));
    chk("R6 cmd strobe B", 32'(b_stb), 32'(sb));
    if (sa) begin
      chk("R6 cmd byte A", 32'(a_rx), 32'(cmd));
      chk("R6 cmd flag A", 32'(a_cmd), 32'd1);
    end
    if (sb) begin
      chk("R6 cmd byte B", 32'(b_rx), 32'(cmd));
      chk("R6 cmd flag B", 32'(b_cmd), 32'd1);
    end
    tx_dir_i = dir[0]; tx_byte_i = dat[0];
    ta = sa && ok && nb > 0 && dir[0];
    tb = sb && ok && nb > 0 && dir[0];
    ack("R6 R8 cmd", nb > 0, sa && ok, sb && ok, 1'b0, ta, tb);
    if (!ok) begin
      modes("R6 invalid command", 2'd0, 2'd0);
      return;
    end
    for (int k = 0; k < nb; k++) begin
      bit last;
      last = (k == nb - 1);
      if (dir[k]) begin
        for (int i = 7; i >= 0; i--) begin
          chk("R11 drive A", 32'(a_txd), 32'(sa));
          chk("R11 drive B", 32'(b_txd), 32'(sb));
          if (sa) chk("R11 bit A", 32'(a_txb), 32'(dat[k][i]));
          if (sb) chk("R11 bit B", 32'(b_txb), 32'(dat[k][i]));
          send_bit(dat[k][i]);
        end
      end else begin
        send_byte(dat[k]);
        chk("R12 data strobe A", 32'(a_stb), 32'(sa));
        chk("R12 data strobe B", 32'(b_stb), 32'(sb));
        if (sa) begin
          chk("R12 data byte A", 32'(a_rx), 32'(dat[k]));
          chk("R12 data flag A", 32'(a_cmd), 32'd0);
        end
        if (sb) begin
          chk("R12 data byte B", 32'(b_rx), 32'(dat[k]));
          chk("R12 data flag B", 32'(b_cmd), 32'd0);
        end
      end
      if (!last) begin
        tx_dir_i = dir[k+1]; tx_byte_i = dat[k+1];
      end
      ack("R8 data", !last, sa, sb, use_hold && k == 0, sa && !last && dir[k+1],
          sb && !last && dir[k+1]);
    end
    modes("R8 clean end", sa ? 2'd1 : 2'd0, sb ? 2'd1 : 2'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; stby_i = 0; hdr_start_i = 0; slot_edge_i = 0; slot_bit_i = 0;
    slot_miss_i = 0; hold_i = 0; cmd_ok_i = 1; tx_dir_i = 0; tx_byte_i = 8'h00;
    repeat (3) @(negedge clk);
    modes("R1 reset", 2'd0, 2'd0);
    chk("R1 reset sak", 32'(a_sak | b_sak), 32'd0);
    chk("R1 reset drive", 32'(a_txd | b_txd), 32'd0);
    rst_n = 1;
    repeat (4) step();

    // Idle ignores headers and bits
    hdr_start_i = 1; step();
    send_byte(8'h55);
    send_bit(1'b1);
    modes("R1 idle ignores", 2'd0, 2'd0);
    chk("R1 idle no sak", 32'(a_sak | b_sak), 32'd0);

    // Clean commands with hold and transmit
    run_txn(1'b0, 8'h00, ADR_A, 1'b0, 1'b1, 2, 1'b1);

    // Back-to-back without standby pulse
    hdr_start_i = 1; step();
    chk("R13 header from standby", 32'(a_mode), 32'd2);
    send_byte(8'h55);
    ack("R13 header", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send_byte(ADR_A);
    ack("R13 address", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    cmd_ok_i = 1;
    send_byte(8'h3C);
    ack("R13 cmd", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R13 back in standby", 32'(a_mode), 32'd1);

    // Bad header value
    stby_i = 1; step();
    hdr_start_i = 1; step();
    send_byte(8'h54);
    modes("R3 bad header", 2'd0, 2'd0);

    // NoMAK after header
    stby_i = 1; step();
    hdr_start_i = 1; step();
    send_byte(8'h55);
    send_bit(1'b0);
    modes("R7 nomak after header", 2'd0, 2'd0);

    // Missing edge inside the command byte
    open_cmd(1'b1);
    send_byte(ADR_A);
    ack("R4 address", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    miss_slot();
    chk("R9 missing edge", 32'(a_mode), 32'd0);

    // Missing edge in a MAK slot
    open_cmd(1'b1);
    send_byte(ADR_A);
    miss_slot();
    chk("R9 missing MAK edge", 32'(a_mode), 32'd0);

    // Standby pulse together with a slot edge mid-byte
    open_cmd(1'b1);
    send_bit(1'b1); send_bit(1'b0);
    stby_i = 1; slot_edge_i = 1; slot_bit_i = 1; step();
    modes("R2 standby beats edge", 2'd1, 2'd1);

    // 12-bit: NoMAK after the high byte
    open_cmd(1'b1);
    send_byte(HI_B);
    send_bit(1'b0);
    chk("R7 nomak after high byte", 32'(b_mode), 32'd0);

    // 12-bit poll, 12-bit full command, invalid command
    run_txn(1'b1, HI_B, DEV_B, 1'b1, 1'b1, 0, 1'b0);
    run_txn(1'b1, HI_B, DEV_B, 1'b0, 1'b1, 3, 1'b1);
    run_txn(1'b1, HI_B, 8'h6D, 1'b0, 1'b1, 1, 1'b0);
    run_txn(1'b0, 8'h00, ADR_A, 1'b0, 1'b0, 1, 1'b0);
    run_txn(1'b0, 8'h00, 8'hA6, 1'b1, 1'b1, 0, 1'b0);

    // Constrained random commands
    for (int t = 0; t < 60; t++) begin
      bit w12, poll, ok, hld;
      logic [7:0] hi, adr;
      int nb;
      w12  = 1'($urandom);
      poll = ($urandom_range(0, 3) == 0);
      ok   = ($urandom_range(0, 4) != 0);
      hld  = ($urandom_range(0, 2) == 0);
      nb   = $urandom_range(0, 3);
      if (w12) begin
        hi  = ($urandom_range(0, 9) < 7) ? HI_B : {4'hF, 4'($urandom)};
        adr = ($urandom_range(0, 9) < 7) ? DEV_B : 8'($urandom);
      end else begin
        hi  = 8'h00;
        adr = ($urandom_range(0, 9) < 7) ? ADR_A : {3'($urandom), 5'($urandom)};
      end
      run_txn(w12, hi, adr, poll, ok, nb, hld);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule